// File: doc/BRIEF.md
# SCSI Mode Control Register with Busy Monitor

This block is the processor-visible mode and initiator-command register pair of a small SCSI bus interface. It holds the arbitrate, DMA-enable, busy-watch and target-role control bits, and it enforces the side effects that go with them. A processor writes bytes over a simple register port. The block decides on each write whether it may update state, whether it may launch a DMA transfer, or whether it must be dropped.

The bus busy line arrives active low and asynchronous. It passes through a synchronizer, and the block compares each synchronized sample with the one before it. If the busy-watch bit is on and the line is seen to fall away, the block raises an interrupt. In the same step it clears the six low initiator-command bits and requests release of every bus signal. Setting the DMA-enable bit works only while the bus is held busy. Once set, that bit stays set until software clears it. While it is set, the request/acknowledge handshake belongs to hardware. Three start offsets launch send, target-receive and initiator-receive transfers. Each start is checked against the role and drive-enable bits. A start that breaks its rule is refused and leaves a sticky error flag.

Top module: `scsiModeReg`

## Requirements
- R1: After reset, both registers read 0x00, and the interrupt, bus release, both error flags and all three start strobes are 0.
- R2: A write to offset 1 stores the whole byte in the initiator-command register, and a write to offset 2 stores the mode register. Reads at offsets 1 and 2 return those registers, and reads at every other offset return 0x00. Writes to offsets 0, 3 and 4 change neither register.
- R3: Mode bit 1 (DMA enable) becomes 1 from a write only when busy has been low on the bus for at least two clocks, so that it is seen through the synchronizer. A write with bit 1 at 0 always clears it. Hardware never clears it.
- R4: While mode bit 2 (busy watch) is 1, a busy line that was sampled asserted and then deasserted sets the interrupt and bus release on the third clock edge after the line rises. The same step zeroes initiator-command bits 5:0 and keeps bits 7:6. While bit 2 is 0, no interrupt follows.
- R5: An accepted write to offset 2 clears the interrupt, the bus release and both error flags.
- R6: With DMA enable at 1, a write to offset 5 gives a one-cycle send strobe only if initiator-command bit 0 (drive data) is 1. Otherwise it gives no strobe and sets the start error flag.
- R7: With DMA enable at 1, a write to offset 6 needs mode bit 6 (target role) at 1, and a write to offset 7 needs it at 0. A write that meets its rule gives a one-cycle strobe. A write that breaks it gives no strobe and sets the start error flag.
- R8: With DMA enable at 0, writes to offsets 5 to 7 give no strobe and set no flag.
- R9: A register write while the DMA busy input is 1 changes no register, gives no strobe and sets the sticky drop error flag.
- R10: The hardware-handshake output equals DMA enable, and the arbitrate output equals mode bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register offset for read and write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the current offset |
| bsyN | input | 1 | Bus busy line, active low, asynchronous |
| dmaBusy | input | 1 | A DMA byte transfer is in flight |
| arbitrate | output | 1 | Arbitration request bit |
| dmaMode | output | 1 | DMA enable bit |
| hwHandshake | output | 1 | Request/acknowledge driven by hardware |
| targetMode | output | 1 | Target role bit |
| icrOut | output | 8 | Initiator-command register contents |
| busIrq | output | 1 | Unexpected busy-loss interrupt |
| busRelease | output | 1 | Release all bus signals |
| startSend | output | 1 | One-cycle DMA send start |
| startTgtRecv | output | 1 | One-cycle DMA target-receive start |
| startIniRecv | output | 1 | One-cycle DMA initiator-receive start |
| startErr | output | 1 | Sticky flag for a refused start write |
| dropErr | output | 1 | Sticky flag for a write dropped during DMA |

## Verification
The assertions assume that the busy line and the DMA busy flag are the only asynchronous or hardware-driven inputs, and that the register port changes only between clock edges. The bench drives every input at the falling edge. It holds the busy line steady for at least three clocks around each change, so that the synchronized history is unambiguous when the start and DMA-enable rules are checked.

// File: rtl/scsiModePkg.sv
package scsiModePkg;
  // register offsets whose decode the block's behaviour depends on
  localparam logic [2:0] OFS_ICR  = 3'd1;
  localparam logic [2:0] OFS_MODE = 3'd2;
  localparam logic [2:0] OFS_SEND = 3'd5;
  localparam logic [2:0] OFS_TGT  = 3'd6;
  localparam logic [2:0] OFS_INI  = 3'd7;

  // mode register bit positions
  localparam int MB_ARB  = 0;
  localparam int MB_DMA  = 1;
  localparam int MB_MON  = 2;
  localparam int MB_TGT  = 6;
  // initiator-command bit positions
  localparam int IB_DRIVE = 0;
  localparam int IB_KEEP  = 6;  // bits at and above this survive busy loss

  typedef struct packed {
    logic wrIcr;
    logic wrMode;
    logic busLoss;
    logic goSend;
    logic goTgt;
    logic goIni;
    logic badStart;
    logic dropped;
  } ctlStrb_t;
endpackage

// File: rtl/scsiModeCtl.sv
module scsiModeCtl
  import scsiModePkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bsyN,
  input  logic              dmaBusy,
  input  logic              dmaOn,
  input  logic              tgtRole,
  input  logic              driveData,
  input  logic              monOn,
  output logic              bsyLive,
  output ctlStrb_t          strb
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] bsyChain;
  logic               bsyPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bsyChain <= '0;
    else       bsyChain <= {bsyChain[CHAIN_W-2:0], ~bsyN};
  end

  assign bsyLive = bsyChain[SYNC_STAGES-1];
  assign bsyPrev = bsyChain[SYNC_STAGES];

  logic accept, hitStart, ruleOk;

  always_comb begin
    accept   = wrEn && !dmaBusy;
    hitStart = accept && dmaOn &&
               (addr == ADDR_W'(OFS_SEND) || addr == ADDR_W'(OFS_TGT) ||
                addr == ADDR_W'(OFS_INI));
    unique case (addr)
      ADDR_W'(OFS_SEND): ruleOk = driveData;
      ADDR_W'(OFS_TGT):  ruleOk = tgtRole;
      ADDR_W'(OFS_INI):  ruleOk = !tgtRole;
      default:           ruleOk = 1'b0;
    endcase

    strb          = '0;
    strb.wrIcr    = accept && addr == ADDR_W'(OFS_ICR);
    strb.wrMode   = accept && addr == ADDR_W'(OFS_MODE);
    strb.busLoss  = monOn && bsyPrev && !bsyLive;
    strb.goSend   = hitStart && ruleOk && addr == ADDR_W'(OFS_SEND);
    strb.goTgt    = hitStart && ruleOk && addr == ADDR_W'(OFS_TGT);
    strb.goIni    = hitStart && ruleOk && addr == ADDR_W'(OFS_INI);
    strb.badStart = hitStart && !ruleOk;
    strb.dropped  = wrEn && dmaBusy;
  end

  // R6
  one_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.goSend, strb.goTgt, strb.goIni, strb.badStart}));
endmodule

// File: rtl/scsiModeRegs.sv
module scsiModeRegs
  import scsiModePkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              bsyLive,
  input  ctlStrb_t          strb,
  output logic [DATA_W-1:0] icrQ,
  output logic [DATA_W-1:0] modeQ,
  output logic              irqQ,
  output logic              sendQ,
  output logic              tgtQ,
  output logic              iniQ,
  output logic              startErrQ,
  output logic              dropErrQ
);
  localparam int LOW_W = IB_KEEP;

  logic [DATA_W-1:0] icrNext, modeNext;

  always_comb begin
    icrNext = strb.wrIcr ? wrData : icrQ;
    if (strb.busLoss) icrNext[LOW_W-1:0] = '0;

    modeNext = modeQ;
    if (strb.wrMode) begin
      modeNext = wrData;
      // enable only while busy is seen; a zero always clears
      modeNext[MB_DMA] = wrData[MB_DMA] ? (bsyLive | modeQ[MB_DMA]) : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      icrQ      <= '0;
      modeQ     <= '0;
      irqQ      <= 1'b0;
      startErrQ <= 1'b0;
      dropErrQ  <= 1'b0;
      sendQ     <= 1'b0;
      tgtQ      <= 1'b0;
      iniQ      <= 1'b0;
    end else begin
      icrQ      <= icrNext;
      modeQ     <= modeNext;
      irqQ      <= strb.busLoss | (irqQ & ~strb.wrMode);
      startErrQ <= strb.badStart | (startErrQ & ~strb.wrMode);
      dropErrQ  <= strb.dropped | (dropErrQ & ~strb.wrMode);
      sendQ     <= strb.goSend;
      tgtQ      <= strb.goTgt;
      iniQ      <= strb.goIni;
    end
  end

  // R3
  dma_set_needs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeQ[MB_DMA]) |-> $past(bsyLive));
  // R3
  dma_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(modeQ[MB_DMA]) |-> $past(strb.wrMode));
  // R4
  loss_clears_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.busLoss |=> (irqQ && icrQ[LOW_W-1:0] == '0));
  // R6
  send_rule_chk: assert property (@(posedge clk) disable iff (!rstN)
    sendQ |-> ($past(modeQ[MB_DMA]) && $past(icrQ[IB_DRIVE])));
  // R7
  recv_rule_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tgtQ || iniQ) |-> ($past(modeQ[MB_DMA]) && tgtQ == $past(modeQ[MB_TGT])));
  // R9
  drop_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.dropped |=> ($stable(icrQ) || $past(strb.busLoss)));
endmodule

// File: rtl/scsiModeReg.sv
module scsiModeReg
  import scsiModePkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              bsyN,
  input  logic              dmaBusy,
  output logic              arbitrate,
  output logic              dmaMode,
  output logic              hwHandshake,
  output logic              targetMode,
  output logic [DATA_W-1:0] icrOut,
  output logic              busIrq,
  output logic              busRelease,
  output logic              startSend,
  output logic              startTgtRecv,
  output logic              startIniRecv,
  output logic              startErr,
  output logic              dropErr
);
  ctlStrb_t          strb;
  logic              bsyLive;
  logic [DATA_W-1:0] icrQ, modeQ;

  scsiModeCtl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) i_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .bsyN(bsyN),
    .dmaBusy(dmaBusy), .dmaOn(modeQ[MB_DMA]), .tgtRole(modeQ[MB_TGT]),
    .driveData(icrQ[IB_DRIVE]), .monOn(modeQ[MB_MON]),
    .bsyLive(bsyLive), .strb(strb)
  );

  scsiModeRegs #(.DATA_W(DATA_W)) i_regs (
    .clk(clk), .rstN(rstN), .wrData(wrData), .bsyLive(bsyLive), .strb(strb),
    .icrQ(icrQ), .modeQ(modeQ), .irqQ(busIrq), .sendQ(startSend),
    .tgtQ(startTgtRecv), .iniQ(startIniRecv), .startErrQ(startErr),
    .dropErrQ(dropErr)
  );

  always_comb begin
    if (addr == ADDR_W'(OFS_ICR))       rdData = icrQ;
    else if (addr == ADDR_W'(OFS_MODE)) rdData = modeQ;
    else                                rdData = '0;
  end

  assign arbitrate   = modeQ[MB_ARB];
  assign dmaMode     = modeQ[MB_DMA];
  assign hwHandshake = modeQ[MB_DMA];
  assign targetMode  = modeQ[MB_TGT];
  assign icrOut      = icrQ;
  assign busRelease  = busIrq;
endmodule

// File: tb/test_scsiModeReg.sv
module test_scsiModeReg;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       bsyN = 1'b1;
  logic       dmaBusy = 1'b0;
  logic       arbitrate, dmaMode, hwHandshake, targetMode;
  logic [7:0] icrOut;
  logic       busIrq, busRelease, startSend, startTgtRecv, startIniRecv;
  logic       startErr, dropErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  scsiModeReg i_scsiModeReg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .bsyN(bsyN), .dmaBusy(dmaBusy), .arbitrate(arbitrate),
    .dmaMode(dmaMode), .hwHandshake(hwHandshake), .targetMode(targetMode),
    .icrOut(icrOut), .busIrq(busIrq), .busRelease(busRelease),
    .startSend(startSend), .startTgtRecv(startTgtRecv),
    .startIniRecv(startIniRecv), .startErr(startErr), .dropErr(dropErr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    idle(2);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    rd(3'd1, v); check("R1 icr", v, 0);
    rd(3'd2, v); check("R1 mode", v, 0);
    check("R1 flags", {busIrq, busRelease, startErr, dropErr}, 0);
    check("R1 strobes", {startSend, startTgtRecv, startIniRecv}, 0);

    // R2 stores, reads and ignored offsets
    idle(1);
    wr(3'd1, 8'hA5);
    wr(3'd2, 8'h41);
    for (int a = 0; a < 8; a++) begin
      if (a != 1 && a != 2) wr(3'(a), 8'hFF);
    end
    rd(3'd1, v); check("R2 icr kept", v, 8'hA5);
    check("R2 icrOut", icrOut, 8'hA5);
    rd(3'd2, v); check("R2 mode kept", v, 8'h41);
    for (int a = 0; a < 8; a++) begin
      if (a != 1 && a != 2) begin
        rd(3'(a), v); check("R2 other reads zero", v, 0);
      end
    end
    // R10 arbitrate follows bit 0, role bit 6
    check("R10 arbitrate", arbitrate, 1);
    check("R7 targetMode", targetMode, 1);
    // R8 starts with DMA off did nothing
    check("R8 no flag", {startErr, startSend, startTgtRecv, startIniRecv}, 0);
    @(negedge clk);

    // R3 gating on busy
    wr(3'd2, 8'h02);
    check("R3 dma refused idle bus", dmaMode, 0);
    bsyN = 1'b0; idle(2);
    wr(3'd2, 8'h02);
    check("R3 dma set busy", dmaMode, 1);
    check("R10 handshake", hwHandshake, 1);
    bsyN = 1'b1; idle(4);
    check("R3 dma held after busy drop", dmaMode, 1);
    check("R4 no irq when watch off", busIrq, 0);
    wr(3'd2, 8'h02);
    check("R3 set refused, still held", dmaMode, 1);
    wr(3'd2, 8'h00);
    check("R3 write zero clears", dmaMode, 0);

    // R6 R7 R8 sweep of start writes
    bsyN = 1'b0; idle(2);
    for (int dm = 0; dm < 2; dm++)
      for (int tg = 0; tg < 2; tg++)
        for (int dr = 0; dr < 2; dr++)
          for (int a = 5; a < 8; a++) begin
            bit ok, eS, eT, eI, eE;
            wr(3'd1, 8'(dr));
            wr(3'd2, 8'((tg << 6) | (dm << 1)));
            wr(3'(a), 8'h00);
            ok = (a == 5) ? dr[0] : (a == 6) ? tg[0] : !tg[0];
            eS = dm[0] && ok && a == 5;
            eT = dm[0] && ok && a == 6;
            eI = dm[0] && ok && a == 7;
            eE = dm[0] && !ok;
            if (a == 5) check("R6 send strobe/err", {startSend, startErr}, {eS, eE});
            else        check("R7 recv strobes/err",
                              {startTgtRecv, startIniRecv, startErr}, {eT, eI, eE});
            if (!dm[0]) check("R8 dma off silent",
                              {startSend, startTgtRecv, startIniRecv, startErr}, 0);
            @(negedge clk);
            check("R6 strobe one cycle", {startSend, startTgtRecv, startIniRecv}, 0);
          end

    // R9 write dropped during DMA byte
    wr(3'd1, 8'h3C);
    wr(3'd2, 8'h02);
    dmaBusy = 1'b1;
    wr(3'd1, 8'hFF);
    wr(3'd2, 8'h00);
    wr(3'd5, 8'h00);
    dmaBusy = 1'b0;
    check("R9 icr unchanged", icrOut, 8'h3C);
    check("R9 mode unchanged", dmaMode, 1);
    check("R9 no strobe", {startSend, startErr}, 0);
    check("R9 drop flag", dropErr, 1);
    wr(3'd2, 8'h00);
    check("R5 write clears drop flag", dropErr, 0);

    // R4 busy loss with watch on
    wr(3'd1, 8'hFF);
    wr(3'd2, 8'h04);
    bsyN = 1'b1;
    idle(2);
    check("R4 not yet", busIrq, 0);
    idle(1);
    check("R4 irq", busIrq, 1);
    check("R4 release", busRelease, 1);
    check("R4 low bits cleared", icrOut, 8'hC0);
    idle(3);
    check("R4 irq sticky", busIrq, 1);
    wr(3'd2, 8'h00);
    check("R5 write clears irq", {busIrq, busRelease}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule